// File: doc/BRIEF.md
# Elapsed Time Counter Synchronizer

This block keeps a free-running local elapsed-time counter. The counter has a coarse field that counts seconds and a fine field that counts fractions of a second. The fine field steps by one on each `tick`. A time message is written into a pending register through a simple write strobe. The message holds a command time, a mode (initialize or synchronize) and a qualifier. The qualifier is the value of the received SpaceWire time-code at which the message must take effect. The message waits until a received time-code equals that qualifier. It is then applied to the counter, and the pending flag is cleared.

Initialize mode copies the whole command time into the counter and marks the counter as in sync. Synchronize mode compares only the coarse field and the top `TC_MAP` bits of the fine field, because `TC_MAP` sets 2^`TC_MAP` time-codes per second. With that comparison it keeps the running counter when the two agree, or when the local count is one time-code step behind the command. In every other case it loads the command time. If the build has no jitter tolerance (`JITTER_EN` = 0), a synchronize message always loads the counter.

Top module: `et_sync`

## Requirements
- R1: After a synchronous active-low reset the coarse and fine fields are zero, and `new_cmd` and `in_sync` are low.
- R2: Each cycle with `tick` high and no load, the fine field increases by one. When the fine field is all ones, it wraps to zero and the coarse field increases by one. The coarse field wraps from all ones to zero.
- R3: A cycle with `msg_wr` high stores the message and raises `new_cmd` on the next cycle. A later write replaces the stored message. `new_cmd` stays high until the message is applied.
- R4: A pending message is applied only in a cycle where `tc_valid` is high and `tc_value` equals the stored qualifier. A time-code with any other value does not change the counter or `new_cmd`.
- R5: Applying an initialize message (`msg_mode` = 0) loads both fields with the command time on the next cycle and sets `in_sync`. `in_sync` then stays high until reset.
- R6: With `JITTER_EN` = 1, applying a synchronize message (`msg_mode` = 1) forms a key for each time. The key is the coarse field followed by the top `TC_MAP` bits of the fine field, taken modulo 2^(COARSE_W+TC_MAP). If the local key equals the command key, or equals the command key minus one, the counter keeps running as if no message had been applied. Otherwise both fields are loaded with the command time. A synchronize message leaves `in_sync` unchanged.
- R7: With `JITTER_EN` = 0, applying a synchronize message always loads the command time.
- R8: `new_cmd` falls on the cycle after the message is applied, unless a new write arrives in the same cycle.
- R9: When a load and a `tick` fall in the same cycle, the counter takes the loaded value and the tick is dropped.
- R10: A write in the same cycle as an apply does not affect that apply, which uses the older message. The new message becomes pending and `new_cmd` stays high.
- R11: With no message pending, time-codes have no effect. The counter changes only on `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Advance the fine field by one |
| msg_wr | input | 1 | Store a new pending time message |
| msg_mode | input | 1 | 0 = initialize, 1 = synchronize |
| msg_coarse | input | COARSE_W | Command coarse time |
| msg_fine | input | FINE_W | Command fine time |
| msg_qual | input | TC_W | Time-code value that qualifies the message |
| tc_valid | input | 1 | Received time-code strobe |
| tc_value | input | TC_W | Received time-code value |
| et_coarse | output | COARSE_W | Local coarse time |
| et_fine | output | FINE_W | Local fine time |
| new_cmd | output | 1 | A message is pending |
| in_sync | output | 1 | Counter has been initialized |

## Verification
Two collisions can occur in the same cycle.

- **Apply and tick.** A qualifying time-code can arrive in the same cycle as a `tick`. The bench provokes this during the synchronize sweep by setting `tick` together with the qualifying `tc_valid` on every other offset. It then checks that a corrected counter shows exactly the command time. It also checks that a counter within tolerance has advanced by one.
- **Apply and write.** A message write can land in the same cycle as the apply of the previous message. The bench checks that the older initialize message is applied. It then checks that `new_cmd` stays high and that the newer message takes effect later, on its own qualifier.

In both cases the expected values come from an integer model in the bench. The model runs on a reduced configuration, against both the tolerant build and the forcing build.

// File: rtl/et_sync_pkg.sv
// Package: shared types for the elapsed-time synchronizer.
package et_sync_pkg;

    // Kind of action a pending time message performs when applied.
    typedef enum logic {
        MODE_INIT = 1'b0,
        MODE_SYNC = 1'b1
    } et_mode_e;

endpackage

// File: rtl/et_time_counter.sv
// Module: et_time_counter
// Holds the local elapsed time as a coarse and a fine field.
// The fine field counts ticks and carries into the coarse field
// when it overflows. A load overrides the tick in the same cycle.
// Assumes: load and tick are synchronous single-cycle qualifiers.
module et_time_counter #(
    parameter int COARSE_W = 32,
    parameter int FINE_W   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                load,
    input  logic [COARSE_W-1:0] ld_coarse,
    input  logic [FINE_W-1:0]   ld_fine,
    output logic [COARSE_W-1:0] coarse,
    output logic [FINE_W-1:0]   fine
);
    localparam int TOTAL_W = COARSE_W + FINE_W;
    localparam logic [FINE_W-1:0] FINE_TOP = {FINE_W{1'b1}};

    logic fine_wrap;

    // Detect the fine field about to overflow.
    always_comb begin
        fine_wrap = (fine == FINE_TOP);
    end

    // Counter register: reset, then load, then tick with carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse <= '0;
            fine   <= '0;
        end else if (load) begin
            coarse <= ld_coarse;
            fine   <= ld_fine;
        end else if (tick) begin
            if (fine_wrap) begin
                fine   <= '0;
                coarse <= coarse + 1'b1;
            end else begin
                fine   <= fine + 1'b1;
            end
        end
    end

    // R2: a tick without a load advances the combined value by one (modular)
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> ({coarse, fine} == TOTAL_W'($past({coarse, fine}) + 1'b1)));

    // R9: a load wins over a tick in the same cycle
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (coarse == $past(ld_coarse) && fine == $past(ld_fine)));

    // R11: with neither load nor tick the counter holds
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> ($stable(coarse) && $stable(fine)));

endmodule

// File: rtl/et_msg_hold.sv
// Module: et_msg_hold
// Stores one pending time message and raises the apply strobe when
// a received time-code matches the stored qualifier. A new write in
// the same cycle replaces the message but leaves that apply intact.
// Assumes: tc_valid is a single-cycle strobe per received code.
module et_msg_hold
    import et_sync_pkg::*;
#(
    parameter int COARSE_W = 32,
    parameter int FINE_W   = 24,
    parameter int TC_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_wr,
    input  et_mode_e            wr_mode,
    input  logic [COARSE_W-1:0] wr_coarse,
    input  logic [FINE_W-1:0]   wr_fine,
    input  logic [TC_W-1:0]     wr_qual,
    input  logic                tc_valid,
    input  logic [TC_W-1:0]     tc_value,
    output et_mode_e            pend_mode,
    output logic [COARSE_W-1:0] pend_coarse,
    output logic [FINE_W-1:0]   pend_fine,
    output logic                new_cmd,
    output logic                apply
);
    logic [TC_W-1:0] pend_qual;
    logic            qual_hit;

    // Compare the received time-code against the stored qualifier.
    always_comb begin
        qual_hit = tc_valid && (tc_value == pend_qual);
        apply    = new_cmd && qual_hit;
    end

    // Pending message storage and the new-command flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_cmd     <= 1'b0;
            pend_mode   <= MODE_INIT;
            pend_coarse <= '0;
            pend_fine   <= '0;
            pend_qual   <= '0;
        end else if (msg_wr) begin
            new_cmd     <= 1'b1;
            pend_mode   <= wr_mode;
            pend_coarse <= wr_coarse;
            pend_fine   <= wr_fine;
            pend_qual   <= wr_qual;
        end else if (apply) begin
            new_cmd     <= 1'b0;
        end
    end

    // R3: a write makes a message pending on the next cycle
    p_wr_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_wr |=> new_cmd);

    // R3: without a time-code strobe a pending message stays pending
    p_pending_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && !tc_valid) |=> new_cmd);

    // R8: an apply without a new write clears the flag
    p_apply_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !msg_wr) |=> !new_cmd);

    // R10: the latest written message is the one kept
    p_wr_replaces_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_wr |=> (pend_coarse == $past(wr_coarse) && pend_fine == $past(wr_fine)));

endmodule

// File: rtl/et_step_cmp.sv
// Module: et_step_cmp
// Decides whether a synchronize message disagrees with the local
// counter at time-code resolution. The key is the coarse field plus
// the top TC_MAP fine bits. The local key may equal the command key
// or lag it by one step. With JITTER_EN = 0 every compare mismatches,
// which forces the load.
// Assumes: TC_MAP <= FINE_W.
module et_step_cmp #(
    parameter int COARSE_W  = 32,
    parameter int TC_MAP    = 6,
    parameter bit JITTER_EN = 1'b1
) (
    input  logic [COARSE_W-1:0] loc_coarse,
    input  logic [TC_MAP-1:0]   loc_step,
    input  logic [COARSE_W-1:0] cmd_coarse,
    input  logic [TC_MAP-1:0]   cmd_step,
    output logic                mismatch
);
    localparam int KEY_W = COARSE_W + TC_MAP;

    generate
        if (JITTER_EN) begin : g_tolerant
            logic [KEY_W-1:0] loc_key;
            logic [KEY_W-1:0] loc_next;
            logic [KEY_W-1:0] cmd_key;

            // Build keys and accept equality or a one-step lag.
            always_comb begin
                loc_key  = {loc_coarse, loc_step};
                cmd_key  = {cmd_coarse, cmd_step};
                loc_next = loc_key + 1'b1;
                mismatch = !((loc_key == cmd_key) || (loc_next == cmd_key));
            end
        end else begin : g_force
            logic unused_in;

            // No tolerance: every synchronize request counts as a mismatch.
            always_comb begin
                unused_in = ^{loc_coarse, loc_step, cmd_coarse, cmd_step};
                mismatch  = 1'b1 | unused_in;
            end
        end
    endgenerate

endmodule

// File: rtl/et_sync.sv
// Module: et_sync (top)
// Local elapsed-time counter that takes a pending time message and
// applies it on a qualifying received time-code. Initialize loads the
// counter and marks it in sync. Synchronize loads only on a mismatch
// at time-code resolution, or always when JITTER_EN = 0.
// Assumes: TC_MAP <= FINE_W; all inputs synchronous to clk.
module et_sync
    import et_sync_pkg::*;
#(
    parameter int COARSE_W  = 32,
    parameter int FINE_W    = 24,
    parameter int TC_W      = 6,
    parameter int TC_MAP    = 6,
    parameter bit JITTER_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                msg_wr,
    input  logic                msg_mode,
    input  logic [COARSE_W-1:0] msg_coarse,
    input  logic [FINE_W-1:0]   msg_fine,
    input  logic [TC_W-1:0]     msg_qual,
    input  logic                tc_valid,
    input  logic [TC_W-1:0]     tc_value,
    output logic [COARSE_W-1:0] et_coarse,
    output logic [FINE_W-1:0]   et_fine,
    output logic                new_cmd,
    output logic                in_sync
);
    localparam int STEP_LSB = FINE_W - TC_MAP;

    et_mode_e            wr_mode;
    et_mode_e            pend_mode;
    logic [COARSE_W-1:0] pend_coarse;
    logic [FINE_W-1:0]   pend_fine;
    logic                apply;
    logic                mismatch;
    logic                do_load;
    logic                do_init;

    // Translate the raw mode bit into the package enum.
    always_comb begin
        wr_mode = msg_mode ? MODE_SYNC : MODE_INIT;
    end

    et_msg_hold #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W),
        .TC_W     (TC_W)
    ) i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .msg_wr      (msg_wr),
        .wr_mode     (wr_mode),
        .wr_coarse   (msg_coarse),
        .wr_fine     (msg_fine),
        .wr_qual     (msg_qual),
        .tc_valid    (tc_valid),
        .tc_value    (tc_value),
        .pend_mode   (pend_mode),
        .pend_coarse (pend_coarse),
        .pend_fine   (pend_fine),
        .new_cmd     (new_cmd),
        .apply       (apply)
    );

    et_step_cmp #(
        .COARSE_W  (COARSE_W),
        .TC_MAP    (TC_MAP),
        .JITTER_EN (JITTER_EN)
    ) i_cmp (
        .loc_coarse (et_coarse),
        .loc_step   (et_fine[FINE_W-1:STEP_LSB]),
        .cmd_coarse (pend_coarse),
        .cmd_step   (pend_fine[FINE_W-1:STEP_LSB]),
        .mismatch   (mismatch)
    );

    // Decide whether the applied message rewrites the counter.
    always_comb begin
        do_init = apply && (pend_mode == MODE_INIT);
        do_load = do_init || (apply && mismatch);
    end

    et_time_counter #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (do_load),
        .ld_coarse (pend_coarse),
        .ld_fine   (pend_fine),
        .coarse    (et_coarse),
        .fine      (et_fine)
    );

    // In-sync flag: set by an applied initialize, kept until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync <= 1'b0;
        end else if (do_init) begin
            in_sync <= 1'b1;
        end
    end

    // R5: once in sync the flag stays set
    p_insync_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |=> in_sync);

    // R5: an applied initialize lands the full command time
    p_init_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && pend_mode == MODE_INIT) |=>
            (in_sync && et_coarse == $past(pend_coarse) && et_fine == $past(pend_fine)));

    // R6: a tolerated synchronize with no tick leaves the counter alone
    p_sync_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && pend_mode == MODE_SYNC && !mismatch && !tick) |=>
            ($stable(et_coarse) && $stable(et_fine)));

    // R11: with nothing pending and no tick the counter is frozen
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_cmd && !tick) |=> ($stable(et_coarse) && $stable(et_fine)));

endmodule

// File: tb/test_et_sync.sv
module test_et_sync;
    localparam int CW   = 8;
    localparam int FW   = 8;
    localparam int TCW  = 3;
    localparam int MAP  = 3;
    localparam int SH   = FW - MAP;
    localparam int TMASK = (1 << (CW + FW)) - 1;
    localparam int KMASK = (1 << (CW + MAP)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic msg_wr = 1'b0;
    logic msg_mode = 1'b0;
    logic [CW-1:0] msg_coarse = '0;
    logic [FW-1:0] msg_fine = '0;
    logic [TCW-1:0] msg_qual = '0;
    logic tc_valid = 1'b0;
    logic [TCW-1:0] tc_value = '0;

    logic [CW-1:0] c0, c1;
    logic [FW-1:0] f0, f1;
    logic n0, n1, s0, s1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int  mval [2];
    bit  msync [2];
    bit  mnew;
    int  pval;
    bit  pmode;
    int  pqual;

    always #4 clk = ~clk;

    et_sync #(.COARSE_W(CW), .FINE_W(FW), .TC_W(TCW), .TC_MAP(MAP), .JITTER_EN(1'b1)) i_et_sync (
        .clk(clk), .rst_n(rst_n), .tick(tick), .msg_wr(msg_wr), .msg_mode(msg_mode),
        .msg_coarse(msg_coarse), .msg_fine(msg_fine), .msg_qual(msg_qual),
        .tc_valid(tc_valid), .tc_value(tc_value),
        .et_coarse(c0), .et_fine(f0), .new_cmd(n0), .in_sync(s0));

    et_sync #(.COARSE_W(CW), .FINE_W(FW), .TC_W(TCW), .TC_MAP(MAP), .JITTER_EN(1'b0)) i_et_sync_force (
        .clk(clk), .rst_n(rst_n), .tick(tick), .msg_wr(msg_wr), .msg_mode(msg_mode),
        .msg_coarse(msg_coarse), .msg_fine(msg_fine), .msg_qual(msg_qual),
        .tc_valid(tc_valid), .tc_value(tc_value),
        .et_coarse(c1), .et_fine(f1), .new_cmd(n1), .in_sync(s1));

    function automatic bit off_step(input int loc, input int cmd);
        int lk = (loc >> SH) & KMASK;
        int ck = (cmd >> SH) & KMASK;
        return !((lk == ck) || (((lk + 1) & KMASK) == ck));
    endfunction

    task automatic check(input string tag);
        for (int k = 0; k < 2; k++) begin
            int got, exp;
            if (k == 0) got = {n0, s0, c0, f0};
            else        got = {n1, s1, c1, f1};
            exp = (int'(mnew) << 17) | (int'(msync[k]) << 16) | mval[k];
            n_cmp++;
            if (got !== exp) begin
                n_bad++;
                $display("FAIL %s inst%0d got new/sync/time=%05h expected %05h", tag, k, got, exp);
            end
        end
    endtask

    // Drive one cycle of stimulus, advance the model, then compare.
    task automatic step(input bit wr, input bit mode, input int val, input int qual,
                        input bit tk, input bit tv, input int tval, input string tag);
        bit app;
        msg_wr = wr; msg_mode = mode;
        msg_coarse = CW'(val >> FW); msg_fine = FW'(val);
        msg_qual = TCW'(qual);
        tick = tk; tc_valid = tv; tc_value = TCW'(tval);
        @(posedge clk); #2;
        app = mnew && tv && (tval == pqual);
        for (int k = 0; k < 2; k++) begin
            if (app) begin
                if (!pmode) begin
                    mval[k] = pval; msync[k] = 1'b1;
                end else if (k == 1 || off_step(mval[k], pval)) begin
                    mval[k] = pval;
                end else if (tk) begin
                    mval[k] = (mval[k] + 1) & TMASK;
                end
            end else if (tk) begin
                mval[k] = (mval[k] + 1) & TMASK;
            end
        end
        if (wr) begin
            mnew = 1'b1; pval = val & TMASK; pmode = mode; pqual = qual;
        end else if (app) begin
            mnew = 1'b0;
        end
        msg_wr = 1'b0; tick = 1'b0; tc_valid = 1'b0;
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL R2 watchdog expired got running expected finished");
        finish_run();
    end

    initial begin
        mval[0] = 0; mval[1] = 0; msync[0] = 0; msync[1] = 0;
        mnew = 0; pval = 0; pmode = 0; pqual = 0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        check("R1");

        // R2: count through a fine overflow into the coarse field
        for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 1, 0, 0, "R2");

        // R11: time-codes with nothing pending, with and without ticks
        for (int v = 0; v < 8; v++) step(0, 0, 0, 0, v[0], 1, v, "R11");

        // R3/R4: pending init message, wrong codes first
        step(0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 0, 16'h1234, 5, 1, 0, 0, "R3");
        for (int v = 0; v < 8; v++) begin
            if (v != 5) step(0, 0, 0, 0, 1, 1, v, "R4");
        end
        step(1, 0, 16'h1357, 5, 0, 0, 0, "R3");
        // R5/R8: qualifying code applies the latest init message
        step(0, 0, 0, 0, 0, 1, 5, "R5");
        step(0, 0, 0, 0, 1, 0, 0, "R8");

        // R6/R7/R9: synchronize sweep over key offsets, tick collisions on odd ones
        for (int d = -4; d <= 4; d++) begin
            for (int lo = 0; lo < 32; lo += 13) begin
                int cmd;
                int q;
                cmd = ((((mval[0] >> SH) + d) << SH) | lo) & TMASK;
                q = (d + 8 + lo) & 7;
                step(1, 1, cmd, q, 0, 0, 0, "R6");
                step(0, 0, 0, 0, 1, 1, (q + 1) & 7, "R4");
                step(0, 0, 0, 0, d[0], 1, q, "R7");
                step(0, 0, 0, 0, 1, 0, 0, "R9");
            end
        end

        // R10: write lands with the apply of the previous message
        step(1, 0, 16'h4020, 2, 0, 0, 0, "R10");
        step(1, 1, 16'h9000, 6, 1, 1, 2, "R10");
        step(0, 0, 0, 0, 1, 1, 2, "R10");
        step(0, 0, 0, 0, 0, 1, 6, "R7");

        // R2: coarse wrap from all ones
        step(1, 0, 16'hFFFD, 1, 0, 1, 1, "R3");
        step(0, 0, 0, 0, 0, 1, 1, "R5");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, 0, "R2");

        finish_run();
    end
endmodule